// File: doc/BRIEF.md
# Serially programmed eight-channel enable register

This block is a two-wire serial bus target that owns a single byte-wide control register. Each bit of that register drives the enable of one of eight downstream channels, so a bus master can switch any mix of channels on or off with one write and can read the current selection back. The block runs from a fast system clock and oversamples the serial clock and data lines. Both lines pass a synchronizer and a run-length filter before START, STOP, bit and acknowledge handling take place.

The target address is a fixed upper nibble combined with three strap inputs, so eight of these blocks can share one bus. There is no sub-address. In a write, every data byte after the address lands in the register, and the value written last is the one that stays. The data line is never driven high: the block only asserts a pull-low enable, and the pad drives it open-drain.

Top module: `chsel_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `ch_en` is 8'h00 and `sda_pull` is 0. The bus logic also returns to idle, so a later transaction behaves the same as one after power-up.
- R2: The target acknowledges (pulls SDA low through the high phase of the ninth clock) an address byte whose upper seven bits, MSB first, equal 1110 followed by `strap[2]`, `strap[1]`, `strap[0]`. Any other address is not acknowledged, and the following data bytes leave `ch_en` unchanged.
- R3: After an acknowledged address with bit 0 (the eighth bit) at 0, a data byte sent MSB first is acknowledged and stored, and `ch_en[n]` then equals bit n of that byte for every n, in any combination.
- R4: When several data bytes follow one write address, `ch_en` ends up holding the last byte.
- R5: A new value reaches `ch_en` only after the acknowledge clock for its byte ends. During the high phase of that ninth clock, `ch_en` still shows the previous value.
- R6: With bit 0 of the address at 1, the target shifts out the register MSB first, one bit per clock. If the master acknowledges a byte, the same register value is sent again. If the master does not acknowledge, the target stops driving until the next START or STOP.
- R7: During a read, `sda_pull` is 0 through the high phase of each acknowledge clock. The target changes `sda_pull` only while the filtered SCL is low, so it never produces a START or STOP.
- R8: A pulse on SCL or SDA that lasts fewer than `FILT_CYCLES` system clocks (default 6, that is 60 ns at 100 MHz) has no effect on the transfer.
- R9: A START that arrives while a byte is in progress (a repeated START) discards that partial byte and restarts address reception.
- R10: A STOP in the middle of a data byte ends the transfer and leaves `ch_en` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset, sampled on `clk`; also stands for power-on reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| strap | input | 3 | Low three bits of the target address |
| sda_pull | output | 1 | 1 pulls the data line low; 0 releases it |
| ch_en | output | 8 | Channel enables; bit n enables channel n+1 |

## Verification
The hardest cases to reach from the ports are the narrow windows between the register's commit and the bus edges. One is the high phase of the ninth clock of a write, when the acknowledge is already on the line but the enables must still show the old value. The other is a spike shorter than the filter window, injected into the SCL low phase and the SDA high phase of a data bit. The bench's bus master can sample inside the acknowledge clock and can inject those short spikes into chosen bits. A wrong commit point or a filter that passes the spike then shows up as a stale or shifted value on `ch_en`. Repeated START and a STOP in the middle of a byte are produced by bit-level tasks that cut a byte after a few bits.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 7;
    localparam int STRAP_W   = 3;
    localparam int BITCNT_W  = $clog2(BYTE_W);
    localparam logic [ADDR_W-STRAP_W-1:0] FIXED_PART = 4'b1110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } link_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    function automatic bus_evt_t decode_events(input logic scl_now, input logic scl_prev,
                                               input logic sda_now, input logic sda_prev);
        bus_evt_t ev;
        ev.start = scl_now & scl_prev & sda_prev & ~sda_now;
        ev.stop  = scl_now & scl_prev & ~sda_prev & sda_now;
        ev.rise  = scl_now & ~scl_prev;
        ev.fall  = ~scl_now & scl_prev;
        return ev;
    endfunction

    function automatic logic addr_hit(input logic [ADDR_W-1:0] rx,
                                      input logic [STRAP_W-1:0] strap);
        return rx == {FIXED_PART, strap};
    endfunction

endpackage

// File: rtl/chsel_glitch_filter.sv
module chsel_glitch_filter #(
    parameter int FILT_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int CNT_W = $clog2(FILT_CYCLES + 1);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            filt    <= 1'b1;
            run_cnt <= '0;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (sync_q[1] == filt) begin
                run_cnt <= '0;
            end else if (run_cnt == CNT_W'(FILT_CYCLES - 1)) begin
                filt    <= sync_q[1];
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // R8: a change of the filtered level needs the synchronized input to have held it
    assert_filter_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt) |-> ($past(sync_q[1], 1) == filt && $past(sync_q[1], 2) == filt));

endmodule

// File: rtl/chsel_bus_fsm.sv
module chsel_bus_fsm
    import chsel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_f,
    input  logic               sda_f,
    input  logic [STRAP_W-1:0] strap,
    output logic               sda_oe,
    output logic [BYTE_W-1:0]  ctrl
);
    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W - 1);

    link_state_t         state;
    logic                scl_p, sda_p;
    logic [BITCNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0]   shreg;
    logic [BYTE_W-1:0]   tx;
    logic                got_byte;
    logic                rw;
    logic                nack;
    bus_evt_t            ev;

    always_comb ev = decode_events(scl_f, scl_p, sda_f, sda_p);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
            bit_cnt  <= '0;
            shreg    <= '0;
            tx       <= '0;
            got_byte <= 1'b0;
            rw       <= 1'b0;
            nack     <= 1'b0;
            sda_oe   <= 1'b0;
            ctrl     <= '0;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
            if (ev.start) begin
                state    <= ST_ADDR;
                bit_cnt  <= '0;
                got_byte <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (ev.stop) begin
                state    <= ST_IDLE;
                got_byte <= 1'b0;
                sda_oe   <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WR: begin
                        if (ev.rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_f};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT) got_byte <= 1'b1;
                        end else if (ev.fall && got_byte) begin
                            got_byte <= 1'b0;
                            if (state == ST_WR) begin
                                sda_oe <= 1'b1;
                                state  <= ST_WR_ACK;
                            end else if (addr_hit(shreg[BYTE_W-1:1], strap)) begin
                                sda_oe <= 1'b1;
                                rw     <= shreg[0];
                                state  <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.fall) begin
                            bit_cnt <= '0;
                            if (rw) begin
                                sda_oe <= ~ctrl[BYTE_W-1];
                                tx     <= {ctrl[BYTE_W-2:0], 1'b0};
                                state  <= ST_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WR;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (ev.fall) begin
                            sda_oe  <= 1'b0;
                            ctrl    <= shreg;
                            bit_cnt <= '0;
                            state   <= ST_WR;
                        end
                    end
                    ST_RD: begin
                        if (ev.fall) begin
                            if (bit_cnt == LAST_BIT) begin
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                                state   <= ST_RD_ACK;
                            end else begin
                                sda_oe  <= ~tx[BYTE_W-1];
                                tx      <= {tx[BYTE_W-2:0], 1'b0};
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.rise) begin
                            nack <= sda_f;
                        end else if (ev.fall) begin
                            if (!nack) begin
                                sda_oe <= ~ctrl[BYTE_W-1];
                                tx     <= {ctrl[BYTE_W-2:0], 1'b0};
                                state  <= ST_RD;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R5: the register only moves on the cycle after the write acknowledge clock ended
    assert_commit_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl) |-> ($past(state) == ST_WR_ACK && !scl_f));

    // R7: the pull-low enable never moves while the filtered clock was high
    assert_sda_moves_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_f));

    // R2: once acknowledging a data byte, the line is held low while the clock is high
    assert_ack_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_ACK && scl_f) |-> (sda_oe && !sda_f));

    // R6: in the master acknowledge slot of a read, the target is not driving
    assert_rd_ack_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACK && scl_f) |-> !sda_oe);

endmodule

// File: rtl/chsel_ctrl.sv
module chsel_ctrl
    import chsel_pkg::*;
#(
    parameter int FILT_CYCLES = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [STRAP_W-1:0] strap,
    output logic               sda_pull,
    output logic [BYTE_W-1:0]  ch_en
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] clean_lines;

    assign raw_lines = {sda_in, scl_in};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        chsel_glitch_filter #(
            .FILT_CYCLES(FILT_CYCLES)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_lines[g]),
            .filt (clean_lines[g])
        );
    end

    chsel_bus_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_f (clean_lines[0]),
        .sda_f (clean_lines[1]),
        .strap (strap),
        .sda_oe(sda_pull),
        .ctrl  (ch_en)
    );

    // R1: leaving reset, all channels are open and the line is released
    assert_reset_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ch_en == '0 && !sda_pull));

endmodule

// File: tb/chsel_ctrl_test.sv
module chsel_ctrl_test;
    localparam int Q = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, scl_gl = 1'b0;
    logic       m_low = 1'b0, sda_gl = 1'b0;
    logic [2:0] strap = 3'd0;
    logic       sda_pull;
    logic [7:0] ch_en;
    logic       inject = 1'b0;
    logic       done = 1'b0;
    int         checks = 0;
    int         fails = 0;
    logic [7:0] model = 8'h00;

    wire scl_line = scl_m | scl_gl;
    wire sda_line = ~(m_low | sda_pull | sda_gl);

    always #5 clk = ~clk;

    chsel_ctrl uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .strap(strap), .sda_pull(sda_pull), .ch_en(ch_en)
    );

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        m_low = 1'b0; w(Q); scl_m = 1'b1; w(Q);
        m_low = 1'b1; w(Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; w(Q); scl_m = 1'b1; w(Q); m_low = 1'b0; w(2*Q);
    endtask

    task automatic send_bit(input logic b);
        m_low = ~b;
        if (inject) begin w(8); scl_gl = 1'b1; w(3); scl_gl = 1'b0; w(Q-11); end
        else w(Q);
        scl_m = 1'b1;
        if (inject && b) begin w(8); sda_gl = 1'b1; w(3); sda_gl = 1'b0; w(2*Q-11); end
        else w(2*Q);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack, output logic [7:0] en_mid);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_low = 1'b0; w(Q); scl_m = 1'b1; w(Q);
        ack = ~sda_line; en_mid = ch_en;
        w(Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] d, output logic rel);
        for (int i = 7; i >= 0; i--) begin
            m_low = 1'b0; w(Q); scl_m = 1'b1; w(Q);
            d[i] = sda_line; w(Q); scl_m = 1'b0; w(Q);
        end
        m_low = mack; w(Q); scl_m = 1'b1; w(Q);
        rel = ~sda_pull; w(Q); scl_m = 1'b0; w(Q);
    endtask

    function automatic logic [7:0] abyte(input logic [2:0] s, input logic rd);
        return {4'b1110, s, rd};
    endfunction

    task automatic write_one(input logic [7:0] v, input string tag);
        logic a0, a1;
        logic [7:0] mid;
        bus_start();
        wr_byte(abyte(strap, 1'b0), a0, mid);
        wr_byte(v, a1, mid);
        bus_stop();
        chk(a0 && a1, {tag, " R2 ack"}, {30'd0, a0, a1}, 32'd3);
        chk(mid == model, {tag, " R5 old value during ack"}, mid, model);
        model = v;
        chk(ch_en == v, {tag, " R3 enables"}, ch_en, v);
    endtask

    task automatic read_n(input int n, input string tag);
        logic a0, rel;
        logic [7:0] mid, d;
        bus_start();
        wr_byte(abyte(strap, 1'b1), a0, mid);
        chk(a0, {tag, " R2 read addr ack"}, a0, 1);
        for (int i = 0; i < n; i++) begin
            rd_byte(i != n-1, d, rel);
            chk(d == model, {tag, " R6 read data"}, d, model);
            chk(rel, {tag, " R7 released in ack slot"}, rel, 1);
        end
        bus_stop();
    endtask

    initial begin
        logic a0, a1;
        logic [7:0] mid, d, vals;
        logic rel;
        w(5);
        chk(ch_en == 8'h00 && !sda_pull, "R1 reset state", {23'd0, sda_pull, ch_en}, 0);
        rst_n = 1'b1;
        w(5);
        chk(ch_en == 8'h00 && !sda_pull, "R1 after reset", {23'd0, sda_pull, ch_en}, 0);

        // strap sweep: each strap value with its own matching address
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            write_one(8'(1 << s) ^ 8'(s << 4), "strap sweep");
        end

        // address mismatch: wrong strap part and wrong fixed part
        strap = 3'd5;
        for (int k = 0; k < 2; k++) begin
            bus_start();
            wr_byte(k == 0 ? abyte(3'd2, 1'b0) : 8'b0110_1010, a0, mid);
            wr_byte(~model, a1, mid);
            bus_stop();
            chk(!a0, "R2 mismatch not acknowledged", a0, 0);
            chk(ch_en == model, "R2 mismatch ignored", ch_en, model);
        end

        // walking ones / zeros and fixed patterns
        for (int i = 0; i < 20; i++) begin
            if (i < 8) vals = 8'(1 << i);
            else if (i < 16) vals = ~8'(1 << (i - 8));
            else vals = (i == 16) ? 8'h00 : (i == 17) ? 8'hFF : (i == 18) ? 8'hA5 : 8'h5A;
            write_one(vals, "pattern");
        end

        // several bytes in one write
        bus_start();
        wr_byte(abyte(strap, 1'b0), a0, mid);
        wr_byte(8'h11, a1, mid);
        wr_byte(8'h22, a1, mid);
        chk(mid == 8'h11, "R5 second byte ack shows first", mid, 8'h11);
        wr_byte(8'hC3, a1, mid);
        bus_stop();
        model = 8'hC3;
        chk(ch_en == 8'hC3, "R4 last byte wins", ch_en, 8'hC3);

        // reads: single byte and repeated bytes on master ack
        read_n(1, "read1");
        write_one(8'h96, "pre-read");
        read_n(3, "read3");

        // repeated start in the middle of a data byte
        bus_start();
        wr_byte(abyte(strap, 1'b0), a0, mid);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        wr_byte(abyte(strap, 1'b0), a0, mid);
        chk(a0, "R9 address after repeated start", a0, 1);
        wr_byte(8'h3C, a1, mid);
        bus_stop();
        model = 8'h3C;
        chk(ch_en == 8'h3C, "R9 repeated start write", ch_en, 8'h3C);

        // repeated start turning a write into a read
        bus_start();
        wr_byte(abyte(strap, 1'b0), a0, mid);
        bus_start();
        wr_byte(abyte(strap, 1'b1), a0, mid);
        rd_byte(1'b0, d, rel);
        bus_stop();
        chk(d == model, "R9 read after repeated start", d, model);

        // stop in the middle of a data byte
        bus_start();
        wr_byte(abyte(strap, 1'b0), a0, mid);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        bus_stop();
        chk(ch_en == model, "R10 stop mid-byte", ch_en, model);

        // short spikes on both lines inside every data bit
        bus_start();
        wr_byte(abyte(strap, 1'b0), a0, mid);
        inject = 1'b1;
        wr_byte(8'hB6, a1, mid);
        inject = 1'b0;
        bus_stop();
        model = 8'hB6;
        chk(ch_en == 8'hB6, "R8 spikes rejected", ch_en, 8'hB6);

        // reset after a write
        write_one(8'hFF, "pre-reset");
        rst_n = 1'b0; w(3); rst_n = 1'b1; w(3);
        model = 8'h00;
        chk(ch_en == 8'h00 && !sda_pull, "R1 reset clears", {23'd0, sda_pull, ch_en}, 0);
        read_n(1, "read after reset R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule